// File: doc/BRIEF.md
# Multiplierless Transposed-Form FIR Filter

This block is a fixed-coefficient, linear-phase low-pass FIR filter that contains no hardware multiplier. Each coefficient is a constant parameter. At elaboration time the block breaks each coefficient into canonical signed digits, so that every constant product is built only from shifted copies of the input sample that are added or subtracted. The digits of a product are combined in nested pairs. Each pair forms the higher digit shifted down to the lower digit, adds the lower digit, and then applies the common shift once. The pair results are summed in a balanced adder tree, which keeps the logic depth logarithmic in the digit count.

The filter is built in transposed direct form. The incoming sample is broadcast to every tap at once, and the registers sit inside the adder chain and hold partial sums. The coefficient set is symmetric, so only the first half of the products (plus the centre tap) is built. Each mirrored tap reuses the product of its partner. A strobe marks each accepted sample. One clock later the filtered result appears, rounded to the output width and saturated.

Top module: `csd_fir_tf`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0, `y_o` is 0 and every partial-sum register is 0. The first output after reset therefore depends only on samples accepted after reset.
- R2: Each cycle with `valid_i` high produces `valid_o` high on the next clock edge, exactly one cycle later.
- R3: A cycle with `valid_i` low leaves the partial sums unchanged. It also leaves `y_o` unchanged and gives `valid_o` low on the next edge, so idle cycles do not count as samples.
- R4: For the n-th accepted sample, the output is derived from the full-precision sum S = sum over k of h[k]*x[n-k], where k runs from 0 to TAPS-1. Here h is the coefficient array taken as Q1.15 fractions, and x holds the 16-bit signed two's-complement samples accepted so far, with zeros before the first one.
- R5: Rounding adds 2^14 to S and then shifts it right arithmetically by 15 bits, so an exact half rounds toward plus infinity. For example, h[0] = -121 with input 16384 gives -60.
- R6: A rounded value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R7: Feeding one sample of -32768 followed by zeros produces the negated coefficient array, one tap per accepted sample. After that the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe: when high, x_i is accepted and the chain advances |
| x_i | input | DW | Input sample, signed two's complement |
| valid_o | output | 1 | Marks y_o as the result of the previous accepted sample |
| y_o | output | OW | Filtered sample, rounded and saturated |

## Verification
A single impulse of full negative scale reads the coefficients back one by one. This separates a wrong digit decomposition in any tap from an error in the register chain's ordering or in the symmetric reuse of products. A half-scale impulse on odd coefficients lands exactly on rounding halves, which separates round-half-up from truncation. Full-scale steps of both signs drive the DC gain above unity and exercise saturation. A moderate step, a table of samples with idle gaps, and a long random sequence are compared with a plain multiply-and-sum model; these show whether idle cycles move the chain and whether partial sums combine correctly across all taps.

// File: rtl/csd_fir_pkg.sv
package csd_fir_pkg;

  // Signed digit (-1, 0, +1) at position pos of the non-adjacent form of c.
  function automatic int csd_digit(input int c, input int pos);
    int n, d, r;
    n = c;
    r = 0;
    for (int i = 0; i <= pos; i++) begin
      if (n[0]) d = (n[1:0] == 2'b01) ? 1 : -1;
      else d = 0;
      if (i == pos) r = d;
      n = (n - d) >>> 1;
    end
    return r;
  endfunction

  function automatic int csd_count(input int c, input int npos);
    int cnt;
    cnt = 0;
    for (int i = 0; i < npos; i++)
      if (csd_digit(c, i) != 0) cnt++;
    return cnt;
  endfunction

  // Position of the k-th nonzero digit, counting up from bit 0.
  function automatic int csd_nth_pos(input int c, input int npos, input int k);
    int cnt, p;
    cnt = 0;
    p = 0;
    for (int i = 0; i < npos; i++) begin
      if (csd_digit(c, i) != 0) begin
        if (cnt == k) p = i;
        cnt++;
      end
    end
    return p;
  endfunction

endpackage

// File: rtl/csd_const_mult.sv
module csd_const_mult #(
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int PW   = DW + CW,
  parameter int COEF = 0
) (
  input  logic signed [DW-1:0] x_i,
  output logic signed [PW-1:0] p_o
);
  import csd_fir_pkg::*;

  localparam int NPOS = CW + 1;
  localparam int ND   = csd_count(COEF, NPOS);
  localparam int NP   = (ND + 1) / 2;
  localparam int NL   = (NP < 1) ? 1 : (1 << $clog2(NP));

  generate
    if (ND == 0) begin : g_zero
      assign p_o = '0;
    end else begin : g_tree
      logic signed [PW-1:0] xe;
      logic signed [PW-1:0] node [2*NL-1];
      assign xe = PW'(x_i);

      for (genvar j = 0; j < NL; j++) begin : g_leaf
        if (j < NP) begin : g_used
          localparam int PLO = csd_nth_pos(COEF, NPOS, 2*j);
          localparam int SLO = csd_digit(COEF, PLO);
          if (2*j + 1 < ND) begin : g_pair
            localparam int PHI = csd_nth_pos(COEF, NPOS, 2*j + 1);
            localparam int SHI = csd_digit(COEF, PHI);
            // nested: (hi << gap +/- lo) << lo_pos
            assign node[NL-1+j] =
              ((((SHI > 0) ? xe : -xe) <<< (PHI - PLO)) + ((SLO > 0) ? xe : -xe)) <<< PLO;
          end else begin : g_single
            assign node[NL-1+j] = ((SLO > 0) ? xe : -xe) <<< PLO;
          end
        end else begin : g_pad
          assign node[NL-1+j] = '0;
        end
      end

      for (genvar i = 0; i < NL - 1; i++) begin : g_add
        assign node[i] = node[2*i+1] + node[2*i+2];
      end

      assign p_o = node[0];
    end
  endgenerate

endmodule

// File: rtl/round_sat.sv
module round_sat #(
  parameter int AW   = 36,
  parameter int OW   = 16,
  parameter int FRAC = 15
) (
  input  logic signed [AW-1:0] a_i,
  output logic signed [OW-1:0] y_o
);
  localparam logic signed [AW:0] HALF = (AW+1)'(1) <<< (FRAC - 1);
  localparam logic signed [AW:0] MAXV = (AW+1)'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [AW:0] MINV = -((AW+1)'(1) <<< (OW - 1));

  logic signed [AW:0] rnd;
  logic signed [AW:0] sh;

  assign rnd = $signed({a_i[AW-1], a_i}) + HALF;
  assign sh  = rnd >>> FRAC;

  always_comb begin
    if (sh > MAXV)      y_o = MAXV[OW-1:0];
    else if (sh < MINV) y_o = MINV[OW-1:0];
    else                y_o = sh[OW-1:0];
  end

endmodule

// File: rtl/csd_fir_tf.sv
module csd_fir_tf #(
  parameter int TAPS = 15,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int OW   = 16,
  parameter int COEF [TAPS] = '{-121, -311, -200, 480, 1650, 3201, 4500, 16000,
                                4500, 3201, 1650, 480, -200, -311, -121}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW-1:0] x_i,
  output logic                 valid_o,
  output logic signed [OW-1:0] y_o
);
  localparam int NU   = (TAPS + 1) / 2;
  localparam int PW   = DW + CW;
  localparam int AW   = PW + $clog2(TAPS);
  localparam int FRAC = CW - 1;

  logic signed [PW-1:0] prod  [NU];
  logic signed [AW-1:0] tap_p [TAPS];
  logic signed [AW-1:0] psum  [TAPS-1];
  logic signed [AW-1:0] acc;
  logic signed [OW-1:0] y_rs;

  // One product per symmetric pair; mirrored taps reuse it.
  generate
    for (genvar u = 0; u < NU; u++) begin : g_mult
      csd_const_mult #(
        .DW  (DW),
        .CW  (CW),
        .PW  (PW),
        .COEF(COEF[u])
      ) u_mult (
        .x_i(x_i),
        .p_o(prod[u])
      );

      localparam logic signed [CW-1:0] CU = CW'(COEF[u]);
      logic signed [PW-1:0] x_w;
      assign x_w = PW'(x_i);
      // R4
      csd_prod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prod[u] == PW'(x_w * CU));
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      localparam int U = (k < NU) ? k : TAPS - 1 - k;
      assign tap_p[k] = AW'(prod[U]);
    end
  endgenerate

  assign acc = tap_p[0] + psum[0];

  round_sat #(
    .AW  (AW),
    .OW  (OW),
    .FRAC(FRAC)
  ) u_rs (
    .a_i(acc),
    .y_o(y_rs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < TAPS - 1; k++) psum[k] <= '0;
      valid_o <= 1'b0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        for (int k = 0; k < TAPS - 2; k++) psum[k] <= tap_p[k+1] + psum[k+1];
        psum[TAPS-2] <= tap_p[TAPS-1];
        y_o <= y_rs;
      end
    end
  end

  // R2
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R3
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R3
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(y_o));

endmodule

// File: tb/csd_fir_tf_test.sv
`timescale 1ns/1ps
module csd_fir_tf_test;
  localparam int TAPS = 15;
  localparam int H [TAPS] = '{-121, -311, -200, 480, 1650, 3201, 4500, 16000,
                              4500, 3201, 1650, 480, -200, -311, -121};
  localparam int NV = 24;
  // {valid, sample}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 16'sd1000},  {1'b1, -16'sd2000}, {1'b0, 16'sd7777},  {1'b1, 16'sd30000},
    {1'b1, 16'sd0},     {1'b0, -16'sd5},    {1'b0, 16'sd123},   {1'b1, -16'sd30000},
    {1'b1, 16'sd12345}, {1'b1, 16'sd1},     {1'b1, -16'sd1},    {1'b0, 16'sd0},
    {1'b1, 16'sd20000}, {1'b1, 16'sd20000}, {1'b1, -16'sd18000},{1'b1, 16'sd500},
    {1'b0, 16'sd9999},  {1'b1, -16'sd777},  {1'b1, 16'sd4096},  {1'b1, 16'sd32767},
    {1'b1, -16'sd32768},{1'b0, 16'sd1},     {1'b1, 16'sd256},   {1'b1, -16'sd9}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [15:0] x_i = '0;
  logic valid_o;
  logic signed [15:0] y_o;

  int n_chk = 0;
  int n_fail = 0;
  int hist [TAPS];
  int last_y = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csd_fir_tf #(.TAPS(TAPS), .COEF(H)) uut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .x_i    (x_i),
    .valid_o(valid_o),
    .y_o    (y_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_out();
    longint s;
    longint r;
    s = 0;
    for (int k = 0; k < TAPS; k++) s += longint'(H[k]) * longint'(hist[k]);
    r = (s + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  // Called at a negedge; returns at the next negedge with outputs checked.
  task automatic push(input bit v, input int x);
    int exp;
    valid_i = v;
    x_i = 16'(x);
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      exp = ref_out();
    end else begin
      exp = last_y;
    end
    @(negedge clk);
    chk(valid_o == v, v ? "R2 valid one cycle later" : "R3 no valid on idle",
        int'(valid_o), int'(v));
    chk(int'(y_o) == exp, v ? "R4 convolution" : "R3 output held", int'(y_o), exp);
    last_y = int'(y_o);
    valid_i = 1'b0;
  endtask

  task automatic flush();
    for (int i = 0; i < TAPS; i++) push(1'b1, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid_o in reset", int'(valid_o), 0);
    chk(y_o == 16'sd0, "R1 y_o in reset", int'(y_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // Table walk: R2, R3, R4
    for (int i = 0; i < NV; i++) push(VEC[i][16], int'($signed(VEC[i][15:0])));
    flush();

    // R7 impulse of -32768 reads back -H
    push(1'b1, -32768);
    chk(int'(y_o) == -H[0], "R7 impulse tap 0", int'(y_o), -H[0]);
    for (int k = 1; k < TAPS; k++) begin
      push(1'b1, 0);
      chk(int'(y_o) == -H[k], "R7 impulse tap", int'(y_o), -H[k]);
    end
    push(1'b1, 0);
    chk(y_o == 16'sd0, "R7 zero after impulse", int'(y_o), 0);

    // R5 rounding halves: -121*16384/32768 = -60.5 -> -60
    push(1'b1, 16384);
    chk(y_o == -16'sd60, "R5 round half up", int'(y_o), -60);
    push(1'b1, 0);
    chk(y_o == -16'sd155, "R5 round half up", int'(y_o), -155);
    flush();

    // Moderate step (R4)
    for (int i = 0; i < TAPS + 3; i++) push(1'b1, 8192);
    flush();

    // R6 saturation both ways
    for (int i = 0; i < TAPS + 2; i++) push(1'b1, 32767);
    chk(y_o == 16'sd32767, "R6 positive saturation", int'(y_o), 32767);
    for (int i = 0; i < TAPS + 2; i++) push(1'b1, -32768);
    chk(y_o == -16'sd32768, "R6 negative saturation", int'(y_o), -32768);
    flush();

    // Random with idle gaps (R2, R3, R4)
    void'($urandom(32'd12345));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom();
      push(r[17:16] != 2'b00, int'($signed(r[15:0])));
    end

    // R1 mid-run reset clears partial sums
    valid_i = 1'b1;
    x_i = 16'sd9000;
    rst_ni = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid_o after reset", int'(valid_o), 0);
    chk(y_o == 16'sd0, "R1 y_o after reset", int'(y_o), 0);
    valid_i = 1'b0;
    rst_ni = 1'b1;
    for (int k = 0; k < TAPS; k++) hist[k] = 0;
    last_y = 0;
    @(negedge clk);
    push(1'b1, 20000);
    chk(int'(y_o) == ((-121 * 20000 + 16384) >>> 15), "R1 first output after reset",
        int'(y_o), (-121 * 20000 + 16384) >>> 15);
    push(1'b1, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule